// File: doc/BRIEF.md
# Status Context Save Stack

This block keeps a processor's status context, made of two arithmetic-status words and one mode-control word, and saves and restores it as a last-in, first-out stack. The live copies of the three words are the top of the stack: software reads them on the output ports and writes them one at a time through a write-enable bus. These direct accesses never move the stack pointer. Below the live top the block holds up to fifteen saved entries. Each saved entry holds all three words together.

A push happens on an explicit push command. It also happens when the sequencer reports that it has taken an interrupt whose identifier is in the auto-push set: the three external request lines and the timer-expiry interrupt. A pop happens on an explicit pop command, on a return-from-interrupt, or on a jump that clears the interrupt state. On every push a programmable mask register clears the selected bits of the live mode word, so a service routine starts with those mode features turned off. The mode word is restored when the routine returns. A status word reports a sticky overflow bit and a non-sticky empty bit. A separate one-cycle pulse reports a pop attempted on an empty stack.

Top module: `ssk_status_stack`

## Requirements
- R1: After a clocked reset with `rst_n` low, the three live words and the mask read zero, `underflow_pulse` is 0, and `sticky_word` reads 0x0100_0000: empty bit 24 is set, overflow bit 23 is clear, and all other bits are zero.
- R2: A `live_we` bit writes `live_wdata` into its live word (bit 0 = `astat_a`, bit 1 = `astat_b`, bit 2 = `mode_word`) at the next edge, and the stack pointer does not move. In any cycle that carries a push or pop request the live writes are dropped. `mask_we` always loads `mask_wdata` into the mask.
- R3: A push stores the three live words as one entry. A later pop puts that entry back into all three live words, in last-in, first-out order.
- R4: At the edge that performs a push, each `mode_word` bit set in the mask held before that edge is cleared. The other mode bits and both arithmetic words keep their values.
- R5: `int_take` with `int_id` 0, 1, 2 (external requests) or 3 (timer expiry) causes a push. `int_take` with any other identifier changes nothing.
- R6: `cmd_rti` and `cmd_jump_ci` each pop the stack, in the same way as `cmd_pop`.
- R7: `sticky_word` bit 24 is 0 from the edge of the first successful push, and returns to 1 at the edge of the pop that removes the last saved entry.
- R8: A push while 15 entries are saved sets `sticky_word` bit 23. The saved entries, the live words and the empty bit stay unchanged.
- R9: Bit 23 stays set until a cycle in which `sticky_clr` is high and no overflowing push occurs. When both happen in the same cycle, the bit stays set.
- R10: A pop on an empty stack leaves the live words and the empty bit unchanged, and raises `underflow_pulse` for the one cycle after that edge.
- R11: When a push request and a pop request arrive in the same cycle, only the push is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_push | input | 1 | Explicit push request |
| cmd_pop | input | 1 | Explicit pop request |
| cmd_rti | input | 1 | Return-from-interrupt, pops |
| cmd_jump_ci | input | 1 | Jump that clears the interrupt state, pops |
| int_take | input | 1 | Sequencer has taken an interrupt this cycle |
| int_id | input | 5 | Identifier of the interrupt taken |
| live_we | input | 3 | Per-word write enables for the live words |
| live_wdata | input | 32 | Data for the live word writes |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 32 | Mask register write data |
| sticky_clr | input | 1 | Clears the sticky overflow bit |
| astat_a | output | 32 | Live arithmetic-status word A |
| astat_b | output | 32 | Live arithmetic-status word B |
| mode_word | output | 32 | Live mode-control word |
| mask_q | output | 32 | Current mask register |
| sticky_word | output | 32 | Bit 23 overflow (sticky), bit 24 empty |
| underflow_pulse | output | 1 | One-cycle pulse after a pop on an empty stack |

## Verification
The stimulus pushes on each way into the stack: the explicit command, the four auto-push interrupt identifiers, and non-pushing identifiers. It then pops through all three pop sources, so that a source wired to the wrong action is caught. The stack is filled with fifteen entries that all differ, checked for overflow, and drained. This catches swapped or lost entries and pointer errors at the full and empty boundaries. Collision cycles are also applied: push with pop, push with a live write, and overflow with sticky clear. Each of these separates the correct priority from the likely wrong one.

// File: rtl/ssk_pkg.sv
// Package: shared word width, context entry type and stack operation codes
// for the status save stack. Assumes all three context words share one width.
package ssk_pkg;

    parameter int unsigned WORD_W = 32;

    // One saved context: both arithmetic-status words and the mode word.
    typedef struct packed {
        logic [WORD_W-1:0] mode;
        logic [WORD_W-1:0] astat_b;
        logic [WORD_W-1:0] astat_a;
    } ctx_t;

    // Action chosen for the current cycle by the request arbiter.
    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_PUSH     = 3'd1,
        OP_PUSH_OVF = 3'd2,
        OP_POP      = 3'd3,
        OP_POP_UNF  = 3'd4
    } stk_op_e;

endpackage

// File: rtl/ssk_arbiter.sv
// Request arbiter: merges the push sources (explicit command and auto-push
// interrupts) and the pop sources (pop, return, clearing jump) into a single
// action for this cycle. Push wins over pop. Assumes full/empty come from
// registered state.
module ssk_arbiter
    import ssk_pkg::*;
#(
    parameter int unsigned INT_ID_W = 5,
    parameter logic [(1<<INT_ID_W)-1:0] AUTO_PUSH_MASK = 'hF
) (
    input  logic                cmd_push,
    input  logic                cmd_pop,
    input  logic                cmd_rti,
    input  logic                cmd_jump_ci,
    input  logic                int_take,
    input  logic [INT_ID_W-1:0] int_id,
    input  logic                stk_full,
    input  logic                stk_empty,
    output stk_op_e             op
);

    logic auto_hit;
    logic push_req;
    logic pop_req;

    // Decide whether the taken interrupt is one that saves context.
    always_comb auto_hit = int_take && AUTO_PUSH_MASK[int_id];

    // Collapse the sources into one push and one pop request.
    always_comb begin
        push_req = cmd_push || auto_hit;
        pop_req  = cmd_pop || cmd_rti || cmd_jump_ci;
    end

    // Pick the action: push first, then pop, each checked against the bounds.
    always_comb begin
        op = OP_IDLE;
        if (push_req) begin
            op = stk_full ? OP_PUSH_OVF : OP_PUSH;
        end else if (pop_req) begin
            op = stk_empty ? OP_POP_UNF : OP_POP;
        end
    end

endmodule

// File: rtl/ssk_storage.sv
// Saved-entry storage: DEPTH context entries below the live top plus an
// occupancy counter. A push writes at the counter; the entry at counter-1 is
// offered as the pop data. Assumes op never requests a push when full or a
// pop when empty (the arbiter downgrades those).
module ssk_storage
    import ssk_pkg::*;
#(
    parameter int unsigned DEPTH = 15
) (
    input  logic    clk,
    input  logic    rst_n,
    input  stk_op_e op,
    input  ctx_t    push_ctx,
    output ctx_t    top_ctx,
    output logic    stk_full,
    output logic    stk_empty
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] count_q;
    ctx_t             entry_q [DEPTH];

    // Occupancy counter: up on a real push, down on a real pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (op == OP_PUSH) begin
            count_q <= count_q + 1'b1;
        end else if (op == OP_POP) begin
            count_q <= count_q - 1'b1;
        end
    end

    // One register per slot; a slot loads when a push lands at its index.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (op == OP_PUSH && count_q == CNT_W'(g)) begin
                entry_q[g] <= push_ctx;
            end
        end
    end

    // Select the most recent saved entry as pop data.
    always_comb begin
        top_ctx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (count_q == CNT_W'(i + 1)) begin
                top_ctx = entry_q[i];
            end
        end
    end

    // Boundary flags taken from the registered count.
    always_comb begin
        stk_full  = (count_q == CNT_W'(DEPTH));
        stk_empty = (count_q == '0);
    end

endmodule

// File: rtl/ssk_live_regs.sv
// Live register set: the two arithmetic-status words and the mode word that
// form the architectural top of stack, plus the push mask. A push clears the
// masked mode bits, a pop reloads all three words, and direct writes apply
// only in cycles with no stack request. Assumes op is already arbitrated.
module ssk_live_regs
    import ssk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op,
    input  logic              stk_req,
    input  ctx_t              pop_ctx,
    input  logic [2:0]        live_we,
    input  logic [WORD_W-1:0] live_wdata,
    input  logic              mask_we,
    input  logic [WORD_W-1:0] mask_wdata,
    output ctx_t              live_ctx,
    output logic [WORD_W-1:0] mask_q
);

    localparam int unsigned NUM_WORDS = 3;
    localparam int unsigned MODE_IDX  = 2;

    logic [WORD_W-1:0] word_q   [NUM_WORDS];
    logic [WORD_W-1:0] pop_word [NUM_WORDS];

    // Split the pop entry into per-word lanes.
    always_comb begin
        pop_word[0] = pop_ctx.astat_a;
        pop_word[1] = pop_ctx.astat_b;
        pop_word[2] = pop_ctx.mode;
    end

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        if (g == MODE_IDX) begin : g_mode
            // Mode word: masked on push, restored on pop, else direct write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q[g] <= '0;
                end else if (op == OP_PUSH) begin
                    word_q[g] <= word_q[g] & ~mask_q;
                end else if (op == OP_POP) begin
                    word_q[g] <= pop_word[g];
                end else if (!stk_req && live_we[g]) begin
                    word_q[g] <= live_wdata;
                end
            end
        end else begin : g_astat
            // Status word: restored on pop, else direct write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q[g] <= '0;
                end else if (op == OP_POP) begin
                    word_q[g] <= pop_word[g];
                end else if (!stk_req && live_we[g]) begin
                    word_q[g] <= live_wdata;
                end
            end
        end
    end

    // Mask register: plain software-written register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    // Repack the live words as a context entry for the push path.
    always_comb begin
        live_ctx.astat_a = word_q[0];
        live_ctx.astat_b = word_q[1];
        live_ctx.mode    = word_q[MODE_IDX];
    end

endmodule

// File: rtl/ssk_flags.sv
// Status flags: sticky overflow, registered underflow pulse, and assembly of
// the status word with overflow and empty at fixed bit positions. Assumes
// stk_empty reflects the registered occupancy.
module ssk_flags
    import ssk_pkg::*;
#(
    parameter int unsigned OVF_BIT   = 23,
    parameter int unsigned EMPTY_BIT = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op,
    input  logic              sticky_clr,
    input  logic              stk_empty,
    output logic [WORD_W-1:0] sticky_word,
    output logic              underflow_pulse
);

    logic ovf_q;
    logic unf_q;

    // Sticky overflow: a set in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (op == OP_PUSH_OVF) begin
            ovf_q <= 1'b1;
        end else if (sticky_clr) begin
            ovf_q <= 1'b0;
        end
    end

    // Underflow pulse: high for the cycle after a pop on an empty stack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unf_q <= 1'b0;
        end else begin
            unf_q <= (op == OP_POP_UNF);
        end
    end

    // Build the status word from the flag bits.
    always_comb begin
        sticky_word            = '0;
        sticky_word[OVF_BIT]   = ovf_q;
        sticky_word[EMPTY_BIT] = stk_empty;
        underflow_pulse        = unf_q;
    end

endmodule

// File: rtl/ssk_status_stack.sv
// Status save stack top: connects the arbiter, saved-entry storage, live
// register set and flag logic. The live words are the top of stack; DEPTH
// entries are saved below them. Assumes one request set per clock.
module ssk_status_stack
    import ssk_pkg::*;
#(
    parameter int unsigned DEPTH     = 15,
    parameter int unsigned INT_ID_W  = 5,
    parameter logic [(1<<INT_ID_W)-1:0] AUTO_PUSH_MASK = 'hF,
    parameter int unsigned OVF_BIT   = 23,
    parameter int unsigned EMPTY_BIT = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_push,
    input  logic                cmd_pop,
    input  logic                cmd_rti,
    input  logic                cmd_jump_ci,
    input  logic                int_take,
    input  logic [INT_ID_W-1:0] int_id,
    input  logic [2:0]          live_we,
    input  logic [WORD_W-1:0]   live_wdata,
    input  logic                mask_we,
    input  logic [WORD_W-1:0]   mask_wdata,
    input  logic                sticky_clr,
    output logic [WORD_W-1:0]   astat_a,
    output logic [WORD_W-1:0]   astat_b,
    output logic [WORD_W-1:0]   mode_word,
    output logic [WORD_W-1:0]   mask_q,
    output logic [WORD_W-1:0]   sticky_word,
    output logic                underflow_pulse
);

    stk_op_e op;
    logic    stk_full;
    logic    stk_empty;
    logic    stk_req;
    ctx_t    live_ctx;
    ctx_t    top_ctx;

    // Any stack action requested this cycle, even one that is refused.
    always_comb stk_req = (op != OP_IDLE);

    ssk_arbiter #(
        .INT_ID_W       (INT_ID_W),
        .AUTO_PUSH_MASK (AUTO_PUSH_MASK)
    ) u_arb (
        .cmd_push    (cmd_push),
        .cmd_pop     (cmd_pop),
        .cmd_rti     (cmd_rti),
        .cmd_jump_ci (cmd_jump_ci),
        .int_take    (int_take),
        .int_id      (int_id),
        .stk_full    (stk_full),
        .stk_empty   (stk_empty),
        .op          (op)
    );

    ssk_storage #(
        .DEPTH (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .push_ctx  (live_ctx),
        .top_ctx   (top_ctx),
        .stk_full  (stk_full),
        .stk_empty (stk_empty)
    );

    ssk_live_regs u_live (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .stk_req    (stk_req),
        .pop_ctx    (top_ctx),
        .live_we    (live_we),
        .live_wdata (live_wdata),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .live_ctx   (live_ctx),
        .mask_q     (mask_q)
    );

    ssk_flags #(
        .OVF_BIT   (OVF_BIT),
        .EMPTY_BIT (EMPTY_BIT)
    ) u_flags (
        .clk             (clk),
        .rst_n           (rst_n),
        .op              (op),
        .sticky_clr      (sticky_clr),
        .stk_empty       (stk_empty),
        .sticky_word     (sticky_word),
        .underflow_pulse (underflow_pulse)
    );

    // Expose the live words on the ports.
    always_comb begin
        astat_a   = live_ctx.astat_a;
        astat_b   = live_ctx.astat_b;
        mode_word = live_ctx.mode;
    end

endmodule

// File: rtl/ssk_status_stack_chk.sv
// Checker for the status save stack: temporal properties on the ports and
// the full flag, attached to every instance of the top by the bind below.
module ssk_status_stack_chk
    import ssk_pkg::*;
#(
    parameter int unsigned INT_ID_W  = 5,
    parameter logic [(1<<INT_ID_W)-1:0] AUTO_PUSH_MASK = 'hF,
    parameter int unsigned OVF_BIT   = 23,
    parameter int unsigned EMPTY_BIT = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_push,
    input logic                cmd_pop,
    input logic                cmd_rti,
    input logic                cmd_jump_ci,
    input logic                int_take,
    input logic [INT_ID_W-1:0] int_id,
    input logic                sticky_clr,
    input logic [WORD_W-1:0]   mode_word,
    input logic [WORD_W-1:0]   mask_q,
    input logic [WORD_W-1:0]   sticky_word,
    input logic                underflow_pulse,
    input logic                stk_full
);

    logic push_any;
    logic pop_any;

    // Request decoding from the ports, written independently of the arbiter.
    always_comb begin
        push_any = cmd_push || (int_take && AUTO_PUSH_MASK[int_id]);
        pop_any  = cmd_pop || cmd_rti || cmd_jump_ci;
    end

    // R9
    ovf_sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_word[OVF_BIT] && !sticky_clr) |=> sticky_word[OVF_BIT]);

    // R10
    unf_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_pulse |-> $past(pop_any && !push_any));

    // R10
    unf_keeps_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_pulse |-> sticky_word[EMPTY_BIT]);

    // R8
    ovf_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_word[OVF_BIT]) |-> !sticky_word[EMPTY_BIT]);

    // R2
    idle_empty_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_any && !pop_any) |=> $stable(sticky_word[EMPTY_BIT]));

    // R4
    push_masks_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_any && !stk_full) |=> ((mode_word & $past(mask_q)) == '0));

    // R7
    push_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_any && !stk_full) |=> !sticky_word[EMPTY_BIT]);

endmodule

bind ssk_status_stack ssk_status_stack_chk #(
    .INT_ID_W       (INT_ID_W),
    .AUTO_PUSH_MASK (AUTO_PUSH_MASK),
    .OVF_BIT        (OVF_BIT),
    .EMPTY_BIT      (EMPTY_BIT)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_push        (cmd_push),
    .cmd_pop         (cmd_pop),
    .cmd_rti         (cmd_rti),
    .cmd_jump_ci     (cmd_jump_ci),
    .int_take        (int_take),
    .int_id          (int_id),
    .sticky_clr      (sticky_clr),
    .mode_word       (mode_word),
    .mask_q          (mask_q),
    .sticky_word     (sticky_word),
    .underflow_pulse (underflow_pulse),
    .stk_full        (stk_full)
);

// File: tb/ssk_status_stack_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model (queue of saved contexts) runs beside
// the design and every output is compared at each falling edge.
module ssk_status_stack_tb_top;

    localparam int DEPTH = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_push = 0, cmd_pop = 0, cmd_rti = 0, cmd_jump_ci = 0;
    logic        int_take = 0;
    logic [4:0]  int_id = '0;
    logic [2:0]  live_we = '0;
    logic [31:0] live_wdata = '0;
    logic        mask_we = 0;
    logic [31:0] mask_wdata = '0;
    logic        sticky_clr = 0;
    logic [31:0] astat_a, astat_b, mode_word, mask_q, sticky_word;
    logic        underflow_pulse;

    int    n_tests = 0;
    int    n_fail  = 0;
    string phase   = "R1";
    bit    done    = 0;

    // Reference model state
    logic [95:0] m_q[$];
    logic [31:0] m_a = 0, m_b = 0, m_m = 0, m_mask = 0;
    bit          m_ovf = 0, m_unf = 0;

    always #2.5 clk = ~clk;

    ssk_status_stack dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_pop(cmd_pop),
        .cmd_rti(cmd_rti), .cmd_jump_ci(cmd_jump_ci), .int_take(int_take),
        .int_id(int_id), .live_we(live_we), .live_wdata(live_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .sticky_clr(sticky_clr),
        .astat_a(astat_a), .astat_b(astat_b), .mode_word(mode_word),
        .mask_q(mask_q), .sticky_word(sticky_word),
        .underflow_pulse(underflow_pulse)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    // Model step at each rising edge from the inputs held since the last fall.
    always @(posedge clk) begin
        bit push, pop;
        logic [95:0] e;
        push = cmd_push || (int_take && int_id < 5'd4);  // R5 ids 0..3
        pop  = cmd_pop || cmd_rti || cmd_jump_ci;
        if (!rst_n) begin
            m_q.delete(); m_a = 0; m_b = 0; m_m = 0; m_mask = 0;
            m_ovf = 0; m_unf = 0;
        end else begin
            m_unf = 0;
            if (push) begin
                if (m_q.size() == DEPTH) m_ovf = 1;
                else begin
                    m_q.push_back({m_m, m_b, m_a});
                    m_m = m_m & ~m_mask;
                end
            end else if (pop) begin
                if (m_q.size() == 0) m_unf = 1;
                else begin
                    e = m_q.pop_back();
                    {m_m, m_b, m_a} = e;
                end
            end else begin
                if (live_we[0]) m_a = live_wdata;
                if (live_we[1]) m_b = live_wdata;
                if (live_we[2]) m_m = live_wdata;
            end
            if (!(push && m_q.size() == DEPTH && m_ovf) || !sticky_clr) begin
                if (sticky_clr && !(push && m_q.size() == DEPTH)) m_ovf = 0;
            end
            if (mask_we) m_mask = mask_wdata;
        end
    end

    // Full comparison every falling edge, tagged with the running phase.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(phase, "astat_a", astat_a, m_a);
            chk(phase, "astat_b", astat_b, m_b);
            chk(phase, "mode_word", mode_word, m_m);
            chk(phase, "mask_q", mask_q, m_mask);
            chk(phase, "sticky_word", sticky_word,
                (32'(m_ovf) << 23) | (32'(m_q.size() == 0) << 24));
            chk(phase, "underflow_pulse", 32'(underflow_pulse), 32'(m_unf));
        end
    end

    task automatic clear_in();
        cmd_push = 0; cmd_pop = 0; cmd_rti = 0; cmd_jump_ci = 0;
        int_take = 0; int_id = '0; live_we = '0; mask_we = 0; sticky_clr = 0;
    endtask

    // Hold the inputs set by the caller for one cycle, then release.
    task automatic cyc();
        @(negedge clk);
        clear_in();
    endtask

    task automatic wr(input int idx, input logic [31:0] v);
        live_we = 3'(1 << idx); live_wdata = v; cyc();
    endtask

    task automatic push();  cmd_push = 1; cyc(); endtask
    task automatic pop();   cmd_pop = 1;  cyc(); endtask

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, sampled before any request
        chk("R1", "astat_a", astat_a, 0);
        chk("R1", "mode_word", mode_word, 0);
        chk("R1", "mask_q", mask_q, 0);
        chk("R1", "sticky_word", sticky_word, 32'h0100_0000);
        chk("R1", "underflow_pulse", 32'(underflow_pulse), 0);

        phase = "R2";
        wr(0, 32'h1111_1111); wr(1, 32'h2222_2222); wr(2, 32'hFFFF_FFFF);
        mask_we = 1; mask_wdata = 32'h0F0F_00FF; cyc();
        chk("R2", "empty after writes", 32'(sticky_word[24]), 1);

        phase = "R4"; push();
        chk("R4", "masked mode", mode_word, 32'hF0F0_FF00);
        phase = "R3";
        wr(0, 32'h3333_3333); wr(2, 32'hAAAA_AAAA); pop();
        chk("R3", "restored mode", mode_word, 32'hFFFF_FFFF);
        chk("R3", "restored a", astat_a, 32'h1111_1111);

        phase = "R2";   // write dropped under a push
        cmd_push = 1; live_we = 3'b111; live_wdata = 32'hDEAD_BEEF; cyc();
        chk("R2", "a kept under push", astat_a, 32'h1111_1111);
        pop();

        phase = "R5";
        for (int i = 0; i < 4; i++) begin
            wr(1, 32'h5000_0000 + i);
            int_take = 1; int_id = 5'(i); cyc();
        end
        foreach (int_id[k]) begin end
        int_take = 1; int_id = 5'd4; cyc();
        int_take = 1; int_id = 5'd31; live_we = 3'b001; live_wdata = 32'h4444; cyc();
        chk("R5", "non-auto id does not push", astat_a, 32'h4444);
        for (int i = 0; i < 4; i++) pop();
        chk("R5", "empty after drain", 32'(sticky_word[24]), 1);

        phase = "R6";
        wr(0, 32'h6060_6060); push(); push(); wr(0, 32'h0);
        cmd_rti = 1; cyc();
        chk("R6", "rti pops", astat_a, 32'h6060_6060);
        wr(0, 32'h0); cmd_jump_ci = 1; cyc();
        chk("R6", "jump pops", astat_a, 32'h6060_6060);
        chk("R7", "empty again", 32'(sticky_word[24]), 1);

        phase = "R11";
        cmd_push = 1; cmd_pop = 1; cyc();
        chk("R11", "push wins", 32'(sticky_word[24]), 0);
        pop();

        phase = "R8";
        for (int i = 0; i < DEPTH; i++) begin
            wr(0, 32'(i)); wr(1, ~32'(i)); wr(2, 32'(i) * 32'h1111);
            mask_we = 1; mask_wdata = 32'(1 << i); cyc();
            push();
        end
        chk("R7", "not empty when full", 32'(sticky_word[24]), 0);
        wr(0, 32'hABCD_0000); push();
        chk("R8", "overflow set", 32'(sticky_word[23]), 1);
        chk("R8", "live kept", astat_a, 32'hABCD_0000);

        phase = "R9";
        sticky_clr = 1; cmd_push = 1; cyc();
        chk("R9", "set beats clear", 32'(sticky_word[23]), 1);
        cyc(); cyc();
        chk("R9", "held", 32'(sticky_word[23]), 1);
        sticky_clr = 1; cyc();
        chk("R9", "cleared", 32'(sticky_word[23]), 0);

        phase = "R3";
        for (int i = 0; i < DEPTH; i++) pop();
        phase = "R10";
        wr(0, 32'h7777_0000);
        cmd_pop = 1; cyc();
        chk("R10", "pulse", 32'(underflow_pulse), 1);
        chk("R10", "live kept", astat_a, 32'h7777_0000);
        cyc();
        chk("R10", "pulse ends", 32'(underflow_pulse), 0);
        cmd_rti = 1; cyc();
        cmd_jump_ci = 1; cyc();
        cyc();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule